// File: doc/BRIEF.md
# Front-Panel Character and Keypad Scanner

This block sits on a simple register bus and drives a front panel made of sixteen alphanumeric LED characters and a small keypad. It lights one character at a time. Software chooses that character with a position counter and writes one segment word, which applies to whichever character is currently lit. Software never writes the counter. It moves the counter by reading particular bus addresses: one read returns the counter to the leftmost character, another read moves it one place to the right, and a third read blanks the segments. Blanking before each advance keeps the old pattern from showing on the next position.

The keypad has six columns of four buttons. It shares the scan with the display: while one of the six leftmost characters is lit, the keypad column with the same index is driven. Reading the keypad address returns the four row lines of that column. Refresh pacing and debouncing are left to software.

Top module: `panel_scan_ctrl`

## Requirements
- R1: After reset, the counter is 0 (character 0 enabled), the segment outputs are all zero and bus_rdata is zero.
- R2: A read at address 0 sets the counter to 0, whatever its previous value.
- R3: A read at address 1 moves the counter up by one. From 15 it wraps to 0.
- R4: A write at address 0 loads bus_wdata bits 14:0 into the segment register, with 1 meaning the segment is lit. Bit 15 is discarded. The new pattern appears on seg_out from the cycle after the write.
- R5: A read at address 2 clears the segment register to zero and leaves the counter unchanged.
- R6: char_en is one-hot. Bit k is set exactly when the counter equals k, where character 0 is the leftmost.
- R7: col_drv bit k (active high) is set only while the counter equals k, for k = 0..5. For counter values 6..15, col_drv is zero.
- R8: A read at address 3 places the active column's rows on bus_rdata bits 3:0 in the following cycle. Bit 0 is the top button and 0 means pressed. Bits 15:4 are zero. When no column is driven, bits 3:0 read 4'hF.
- R9: A write at address 1, 2 or 3 changes neither the counter nor the segment register. A read at address 0, 1 or 2 returns zero on bus_rdata.
- R10: The segment register keeps its value when the counter is advanced or reset by a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address: 0 select/segments, 1 next, 2 blank, 3 keypad |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered, valid the cycle after a read |
| key_rows | input | 4 | Row lines of the driven keypad column, 0 = pressed |
| char_en | output | 16 | One-hot character enable, bit 0 leftmost |
| seg_out | output | 15 | Segment pattern of the lit character |
| col_drv | output | 6 | Keypad column drive, active high |

## Verification
A counter that drifts or skips a position shows up on the very next cycle as a char_en bit in the wrong place. It also shows as a column drive that no longer lines up with the lit character, so the bench compares both ports against a model position after every bus access. A segment register that is cleared, left unblanked or loaded with bit 15 shows up at once on seg_out. A wrong column-to-row mapping does not show at the ports until software reads the keypad. For that reason, rows are read at every one of the sixteen positions, with buttons pressed in different columns.

// File: rtl/panel_pkg.sv
package panel_pkg;
  typedef enum logic [1:0] {
    PNL_SEL   = 2'd0,
    PNL_NEXT  = 2'd1,
    PNL_BLANK = 2'd2,
    PNL_KEYS  = 2'd3
  } panel_addr_e;
endpackage

// File: rtl/panel_char_counter.sv
module panel_char_counter #(
  parameter int CHARS = 16,
  localparam int CW = $clog2(CHARS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LAST = CW'(CHARS - 1);

  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | inc;
    cnt_d  = cnt;
    if (clr)              cnt_d = '0;
    else if (cnt == LAST) cnt_d = '0;
    else                  cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  // R2: a reset read returns the scan to the leftmost character
  a_r2_home: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);
  // R3: advance by one, wrapping after the last character
  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> cnt == (($past(cnt) == LAST) ? '0 : $past(cnt) + 1'b1));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/panel_seg_reg.sv
module panel_seg_reg #(
  parameter int SEG_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             blank,
  input  logic [SEG_W-1:0] wdata,
  output logic [SEG_W-1:0] seg
);
  logic [SEG_W-1:0] seg_d;
  logic             seg_en;

  always_comb begin
    seg_en = load | blank;
    seg_d  = blank ? '0 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seg <= '0;
    else if (seg_en) seg <= seg_d;
  end

  // R4: written pattern appears the cycle after the write
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !blank) |=> seg == $past(wdata));
  // R5: blanking read clears every segment
  a_r5_blank: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> seg == '0);
  // R10: pattern is held without a load or blank
  a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !blank) |=> $stable(seg));
endmodule

// File: rtl/panel_select_decode.sv
module panel_select_decode #(
  parameter int CHARS = 16,
  parameter int KEY_COLS = 6,
  parameter int KEY_ROWS = 4,
  localparam int CW = $clog2(CHARS)
) (
  input  logic [CW-1:0]       cnt,
  input  logic [KEY_ROWS-1:0] key_rows,
  output logic [CHARS-1:0]    char_en,
  output logic [KEY_COLS-1:0] col_drv,
  output logic [KEY_ROWS-1:0] rows_sel
);
  for (genvar k = 0; k < CHARS; k++) begin : g_char
    assign char_en[k] = (cnt == CW'(k));
  end

  for (genvar k = 0; k < KEY_COLS; k++) begin : g_col
    assign col_drv[k] = char_en[k];
  end

  always_comb begin
    rows_sel = (|col_drv) ? key_rows : '1;
  end

  // R6: exactly one character lit
  always_comb begin
    a_r6_onehot: assert ($countones(char_en) == 1);
  end
  // R7: at most one column, and only alongside its character
  always_comb begin
    a_r7_col_single: assert ($onehot0(col_drv));
  end
endmodule

// File: rtl/panel_scan_ctrl.sv
module panel_scan_ctrl #(
  parameter int CHARS    = 16,
  parameter int SEG_W    = 15,
  parameter int KEY_COLS = 6,
  parameter int KEY_ROWS = 4,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [KEY_ROWS-1:0] key_rows,
  output logic [CHARS-1:0]    char_en,
  output logic [SEG_W-1:0]    seg_out,
  output logic [KEY_COLS-1:0] col_drv
);
  import panel_pkg::*;

  localparam int CW = $clog2(CHARS);

  logic [1:0]          rst_q;
  logic                rst_i_n;
  logic                rd_stb, wr_stb;
  logic                do_home, do_next, do_blank, do_load, do_keys;
  logic [CW-1:0]       cnt;
  logic [KEY_ROWS-1:0] rows_sel;
  logic [DATA_W-1:0]   rdata_d;
  logic                unused_wbits;

  assign unused_wbits = ^bus_wdata[DATA_W-1:SEG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  always_comb begin
    rd_stb   = bus_sel & ~bus_wr;
    wr_stb   = bus_sel & bus_wr;
    do_home  = rd_stb & (bus_addr == PNL_SEL);
    do_next  = rd_stb & (bus_addr == PNL_NEXT);
    do_blank = rd_stb & (bus_addr == PNL_BLANK);
    do_keys  = rd_stb & (bus_addr == PNL_KEYS);
    do_load  = wr_stb & (bus_addr == PNL_SEL);
  end

  panel_char_counter #(.CHARS(CHARS)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .clr(do_home), .inc(do_next), .cnt(cnt)
  );

  panel_seg_reg #(.SEG_W(SEG_W)) u_seg (
    .clk(clk), .rst_n(rst_i_n), .load(do_load), .blank(do_blank),
    .wdata(bus_wdata[SEG_W-1:0]), .seg(seg_out)
  );

  panel_select_decode #(.CHARS(CHARS), .KEY_COLS(KEY_COLS), .KEY_ROWS(KEY_ROWS)) u_dec (
    .cnt(cnt), .key_rows(key_rows), .char_en(char_en), .col_drv(col_drv),
    .rows_sel(rows_sel)
  );

  always_comb begin
    rdata_d = '0;
    if (do_keys) rdata_d = {{(DATA_W-KEY_ROWS){1'b0}}, rows_sel};
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)    bus_rdata <= '0;
    else if (rd_stb) bus_rdata <= rdata_d;
  end

  // R8: idle keypad read reports all rows released
  a_r8_idle_rows: assert property (@(posedge clk) disable iff (!rst_i_n)
    (do_keys && col_drv == '0) |=> bus_rdata == DATA_W'(2**KEY_ROWS - 1));
  // R9: writes to the strobe addresses leave panel state alone
  a_r9_wr_ignored: assert property (@(posedge clk) disable iff (!rst_i_n)
    (wr_stb && bus_addr != PNL_SEL) |=> ($stable(seg_out) && $stable(char_en)));
  // R9: non-keypad reads return zero
  a_r9_rd_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_stb && bus_addr != PNL_KEYS) |=> bus_rdata == '0);
endmodule

// File: tb/tb_panel_scan_ctrl.sv
`timescale 1ns/1ps
module tb_panel_scan_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [3:0]  key_rows;
  logic [15:0] char_en;
  logic [14:0] seg_out;
  logic [5:0]  col_drv;

  always #2.5 clk = ~clk;

  panel_scan_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .key_rows(key_rows), .char_en(char_en), .seg_out(seg_out), .col_drv(col_drv)
  );

  // keypad matrix: pressed[c][r] pulls row r low while column c is driven
  logic [3:0] pressed [6];
  always_comb begin
    key_rows = 4'hF;
    for (int c = 0; c < 6; c++)
      if (col_drv[c]) key_rows = key_rows & ~pressed[c];
  end

  int errors = 0, checks = 0;
  int m_cnt;
  logic [14:0] m_seg;
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen;
  bit          done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= bus_sel && !bus_wr;

  // monitor: pops the expected read data one cycle after each read
  always @(negedge clk) begin
    if (rd_seen && rst_n) begin
      if (exp_q.size() == 0) begin
        errors++; checks++;
        $display("FAIL R8 actual=%h expected=none", bus_rdata);
      end else begin
        chk(tag_q.pop_front(), {16'h0, bus_rdata}, {16'h0, exp_q.pop_front()});
      end
    end
  end

  function automatic logic [3:0] exp_rows();
    if (m_cnt < 6) return 4'hF & ~pressed[m_cnt];
    return 4'hF;
  endfunction

  task automatic check_ports(string tag);
    chk({tag, " char_en"}, {16'h0, char_en}, 32'd1 << m_cnt);
    chk({tag, " seg"}, {17'h0, seg_out}, {17'h0, m_seg});
    chk({tag, " col"}, {26'h0, col_drv}, (m_cnt < 6) ? (32'd1 << m_cnt) : 32'd0);
  endtask

  task automatic op(bit wr, logic [1:0] addr, logic [15:0] data, string tag);
    @(negedge clk);
    if (!wr) begin
      exp_q.push_back(addr == 2'd3 ? {12'h0, exp_rows()} : 16'h0);
      tag_q.push_back({tag, " rdata"});
    end
    bus_sel = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = data;
    if (!wr && addr == 2'd0) m_cnt = 0;
    if (!wr && addr == 2'd1) m_cnt = (m_cnt + 1) % 16;
    if (!wr && addr == 2'd2) m_seg = '0;
    if (wr && addr == 2'd0)  m_seg = data[14:0];
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    check_ports(tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 6; c++) pressed[c] = 4'h0;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0; m_cnt = 0; m_seg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_ports("R1 reset");
    chk("R1 rdata", {16'h0, bus_rdata}, 32'h0);

    op(1, 2'd0, 16'hFFFF, "R4 load bit15 dropped");
    pressed[0] = 4'b0100;
    op(0, 2'd3, 0, "R8 col0 row2");
    op(0, 2'd1, 0, "R3 R10 advance keeps seg");
    op(1, 2'd1, 16'h1234, "R9 write next ignored");
    op(1, 2'd2, 16'h0F0F, "R9 write blank ignored");
    op(1, 2'd3, 16'h5555, "R9 write keys ignored");
    op(1, 2'd0, 16'h2A55, "R4 load pattern");

    pressed[1] = 4'b0011; pressed[3] = 4'b1000; pressed[5] = 4'b1111;
    op(0, 2'd0, 0, "R2 home");
    for (int i = 0; i < 16; i++) begin
      op(0, 2'd3, 0, "R7 R8 scan keys");
      op(0, 2'd2, 0, "R5 blank");
      op(1, 2'd0, 16'(16'h0100 + i), "R4 per char");
      op(0, 2'd1, 0, "R3 R6 advance");
    end
    op(0, 2'd0, 0, "R9 home reads zero");
    for (int i = 0; i < 9; i++) op(0, 2'd1, 0, "R3 step");
    op(0, 2'd3, 0, "R8 idle rows F");
    op(0, 2'd0, 0, "R2 home from 9");
    op(0, 2'd3, 0, "R8 col0 again");
    for (int i = 0; i < 16; i++) op(0, 2'd1, 0, "R3 wrap");
    op(0, 2'd2, 0, "R5 blank at 0");
    repeat (2) @(negedge clk);
    chk("R8 queue drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule